// File: doc/BRIEF.md
# Synchronous microprocessor bus slave with wait handshake

This block is the slave side of a 16-bit synchronous microprocessor bus. Everything runs on the bus clock. The bus has a chip select, a space-select line that picks memory space or register space, a 21-bit address and four active-low byte-lane strobes. Each of the two byte lanes has its own read strobe and its own write strobe. When an access begins, the block pulls its wait line low at once so that the master is stalled. The block then passes the access to an internal request/acknowledge port that serves a register file or a memory. It releases wait on the clock edge where the acknowledge is sampled, and it stops driving wait and the data lanes as soon as the strobes are deasserted.

Tri-state pads are represented by separate output-enable signals: one for wait and one for each data byte lane. The pad cells outside the block combine each value with its enable. The bus inputs are registered on the bus clock. A controller with three states sequences the access:

- **IDLE**: waits for a registered access.
- **REQ**: holds the internal request until it is acknowledged.
- **DONE**: wait is released, and the controller waits for every strobe to be sampled high.

The transitions are:

- IDLE to REQ on a sampled access.
- REQ to DONE on acknowledge.
- DONE to IDLE once all strobes are sampled high.

Top module: `mpu_wait_slave`

## Requirements
- R1: After reset, with chip select and every strobe high, `wait_oe` is 0, `bus_doe` is 2'b00 and `req_valid` is 0.
- R2: While `bus_cs_n` is 0 and any of the four strobes is 0, `wait_oe` is 1 with no clock edge needed. `wait_out_n` stays 0 until the access has been acknowledged.
- R3: Call the first rising edge that samples chip select and a strobe both low the sampling edge. `req_valid` becomes 1 after the next rising edge. It stays 1, with its request fields stable, until the edge where `req_ready` is sampled 1. After that edge it is 0.
- R4: `wait_out_n` is 0 while the request waits. It becomes 1 after the rising edge that samples `req_valid` and `req_ready` both 1, and it stays 1 until the strobes are released.
- R5: The request fields are set as follows. `req_write` is 1 when any write strobe is low. `req_space` copies `bus_space`. `req_addr` copies `bus_addr`. `req_be` bit 0 is 1 when the low-lane strobe (data bits 7:0) is low, and bit 1 is 1 when the high-lane strobe (data bits 15:8) is low.
- R6: `req_wdata` is the value on `bus_din` at the second rising edge after chip select and a write strobe are both low.
- R7: `bus_doe[0]` is 1 only while chip select and the low read strobe are low, and `bus_doe[1]` is 1 only while chip select and the high read strobe are low. On a read, `bus_dout` carries the `req_rdata` that was sampled with `req_ready` no later than the edge where `wait_out_n` rises.
- R8: When all strobes return high, `wait_oe` and `bus_doe` fall to 0 with no clock edge needed.
- R9: After an acknowledged access, no new request is issued until every strobe has been sampled high at a rising edge. Strobes held low after completion produce no second request, and `wait_out_n` stays 1.
- R10: A write drives `req_be` with 0 for every lane whose strobe is high. Reading back afterwards returns that lane's previous content unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_space | input | 1 | Space select: 1 memory, 0 registers |
| bus_addr | input | 21 | Bus address |
| bus_rd_lo_n | input | 1 | Read strobe, data bits 7:0 |
| bus_rd_hi_n | input | 1 | Read strobe, data bits 15:8 |
| bus_wr_lo_n | input | 1 | Write strobe, data bits 7:0 |
| bus_wr_hi_n | input | 1 | Write strobe, data bits 15:8 |
| bus_din | input | 16 | Data from the master |
| bus_dout | output | 16 | Read data toward the pads |
| bus_doe | output | 2 | Per-lane data output enable |
| wait_out_n | output | 1 | Wait level, low stalls the master |
| wait_oe | output | 1 | Wait output enable |
| req_valid | output | 1 | Internal request pending |
| req_write | output | 1 | Request is a write |
| req_space | output | 1 | Request space select |
| req_addr | output | 21 | Request address |
| req_be | output | 2 | Request byte enables |
| req_wdata | output | 16 | Request write data |
| req_ready | input | 1 | Internal acknowledge |
| req_rdata | input | 16 | Internal read data |

## Verification
Some rules are checked by the embedded assertions on every clock:

- A pending request stays stable until it is acknowledged.
- `wait_out_n` is high on the cycle after the acknowledge.
- A request never coexists with a released wait.
- The DONE state never issues a second request while strobes are still seen low.
- A data lane is only enabled under chip select and its own read strobe.

Other behaviours are shown only by the bench scenarios:

- The combinational rise and fall of the enables between clock edges.
- The exact edge on which the request appears.
- The write data captured from the bus.
- Preserving untouched byte lanes across a partial write and a later read-back.
- Holding the strobes low after completion.

// File: rtl/mpu_slv_pkg.sv
package mpu_slv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DONE = 2'd2
    } acc_state_t;

    function automatic logic any_low(input logic [1:0] v_n);
        return (v_n != 2'b11);
    endfunction

endpackage

// File: rtl/mpu_in_sync.sv
module mpu_in_sync #(
    parameter int ADDR_W = 21,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              space,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  rd_n,
    input  logic [LANES-1:0]  wr_n,
    output logic              s_cs_n,
    output logic              s_space,
    output logic [ADDR_W-1:0] s_addr,
    output logic [LANES-1:0]  s_rd_n,
    output logic [LANES-1:0]  s_wr_n
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_cs_n  <= 1'b1;
            s_space <= 1'b0;
            s_addr  <= '0;
            s_rd_n  <= '1;
            s_wr_n  <= '1;
        end else begin
            s_cs_n  <= cs_n;
            s_space <= space;
            s_addr  <= addr;
            s_rd_n  <= rd_n;
            s_wr_n  <= wr_n;
        end
    end

endmodule

// File: rtl/mpu_acc_fsm.sv
module mpu_acc_fsm
    import mpu_slv_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_cs_n,
    input  logic              s_space,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [LANES-1:0]  s_rd_n,
    input  logic [LANES-1:0]  s_wr_n,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              req_ready,
    input  logic [DATA_W-1:0] req_rdata,
    output logic              req_valid,
    output logic              req_write,
    output logic              req_space,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LANES-1:0]  req_be,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rdata_q,
    output logic              wait_out_n
);

    acc_state_t state, state_nx;
    logic       seen_access;
    logic       seen_idle;
    logic       seen_write;

    assign seen_write  = (s_wr_n != '1);
    assign seen_access = !s_cs_n && (seen_write || (s_rd_n != '1));
    assign seen_idle   = (s_rd_n == '1) && (s_wr_n == '1);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (seen_access) state_nx = ST_REQ;
            ST_REQ:  if (req_ready)   state_nx = ST_DONE;
            ST_DONE: if (seen_idle)   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_write <= 1'b0;
            req_space <= 1'b0;
            req_addr  <= '0;
            req_be    <= '0;
            req_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            if (state == ST_IDLE && seen_access) begin
                req_write <= seen_write;
                req_space <= s_space;
                req_addr  <= s_addr;
                req_be    <= seen_write ? ~s_wr_n : ~s_rd_n;
                req_wdata <= bus_din;
            end
            if (state == ST_REQ && req_ready) begin
                rdata_q <= req_rdata;
            end
        end
    end

    assign req_valid  = (state == ST_REQ);
    assign wait_out_n = (state == ST_DONE);

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_be)
                                       && $stable(req_write) && $stable(req_wdata)));

    a_r4_wait_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> wait_out_n);

    a_r4_wait_low_pending: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !wait_out_n);

    a_r9_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_out_n && !seen_idle) |=> !req_valid);

endmodule

// File: rtl/mpu_pad_ctl.sv
module mpu_pad_ctl #(
    parameter int LANES = 2,
    localparam int DATA_W = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [LANES-1:0]  rd_n,
    input  logic [LANES-1:0]  wr_n,
    input  logic [DATA_W-1:0] rdata_q,
    output logic [DATA_W-1:0] dout,
    output logic [LANES-1:0]  doe,
    output logic              wait_oe
);

    assign wait_oe = !cs_n && ((rd_n != '1) || (wr_n != '1));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign doe[g]           = !cs_n && !rd_n[g];
        assign dout[g*8 +: 8]   = rdata_q[g*8 +: 8];

        a_r7_lane_oe: assert property (@(posedge clk) disable iff (!rst_n)
            doe[g] |-> (wait_oe && !rd_n[g]));
    end

endmodule

// File: rtl/mpu_wait_slave.sv
module mpu_wait_slave #(
    parameter int ADDR_W = 21,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_space,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd_lo_n,
    input  logic              bus_rd_hi_n,
    input  logic              bus_wr_lo_n,
    input  logic              bus_wr_hi_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic [LANES-1:0]  bus_doe,
    output logic              wait_out_n,
    output logic              wait_oe,
    output logic              req_valid,
    output logic              req_write,
    output logic              req_space,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LANES-1:0]  req_be,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              req_ready,
    input  logic [DATA_W-1:0] req_rdata
);

    logic [LANES-1:0]  rd_n, wr_n, s_rd_n, s_wr_n;
    logic              s_cs_n, s_space;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] rdata_q;

    assign rd_n = {bus_rd_hi_n, bus_rd_lo_n};
    assign wr_n = {bus_wr_hi_n, bus_wr_lo_n};

    mpu_in_sync #(.ADDR_W(ADDR_W), .LANES(LANES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n(bus_cs_n), .space(bus_space), .addr(bus_addr),
        .rd_n(rd_n), .wr_n(wr_n),
        .s_cs_n(s_cs_n), .s_space(s_space), .s_addr(s_addr),
        .s_rd_n(s_rd_n), .s_wr_n(s_wr_n)
    );

    mpu_acc_fsm #(.ADDR_W(ADDR_W), .LANES(LANES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .s_cs_n(s_cs_n), .s_space(s_space), .s_addr(s_addr),
        .s_rd_n(s_rd_n), .s_wr_n(s_wr_n),
        .bus_din(bus_din),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_space(req_space),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rdata_q(rdata_q), .wait_out_n(wait_out_n)
    );

    mpu_pad_ctl #(.LANES(LANES)) u_pad (
        .clk(clk), .rst_n(rst_n),
        .cs_n(bus_cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .rdata_q(rdata_q), .dout(bus_dout), .doe(bus_doe), .wait_oe(wait_oe)
    );

    a_r2_wait_driven_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bus_cs_n && (rd_n != 2'b11 || wr_n != 2'b11)) |-> (wait_oe && !wait_out_n));

endmodule

// File: tb/mpu_wait_slave_tb.sv
module mpu_wait_slave_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_cs_n = 1, bus_space = 0;
    logic [20:0] bus_addr = '0;
    logic        bus_rd_lo_n = 1, bus_rd_hi_n = 1, bus_wr_lo_n = 1, bus_wr_hi_n = 1;
    logic [15:0] bus_din = '0;
    logic [15:0] bus_dout;
    logic [1:0]  bus_doe;
    logic        wait_out_n, wait_oe;
    logic        req_valid, req_write, req_space;
    logic [20:0] req_addr;
    logic [1:0]  req_be;
    logic [15:0] req_wdata;
    logic        req_ready = 0;
    logic [15:0] req_rdata = '0;

    int checks = 0, fails = 0;
    int resp_lat = 0, resp_cnt = 0;
    bit done_flag = 0;
    logic [15:0] mem_model [32];
    logic [15:0] exp_mem   [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpu_wait_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_space(bus_space),
        .bus_addr(bus_addr), .bus_rd_lo_n(bus_rd_lo_n), .bus_rd_hi_n(bus_rd_hi_n),
        .bus_wr_lo_n(bus_wr_lo_n), .bus_wr_hi_n(bus_wr_hi_n), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .wait_out_n(wait_out_n), .wait_oe(wait_oe),
        .req_valid(req_valid), .req_write(req_write), .req_space(req_space),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] f_merge(input logic [15:0] old_v, input logic [15:0] new_v,
                                            input logic [1:0] lanes);
        logic [15:0] m;
        m = {{8{lanes[1]}}, {8{lanes[0]}}};
        return (old_v & ~m) | (new_v & m);
    endfunction

    function automatic int f_idx(input bit sp, input logic [20:0] a);
        return {27'd0, sp, a[3:0]};
    endfunction

    // internal responder acting as the memory behind the port
    initial begin
        forever begin
            @(negedge clk);
            if (req_ready) begin
                req_ready = 0;
                chk(wait_out_n == 1, "R4", "wait high after ready edge", wait_out_n, 1);
            end else if (req_valid) begin
                if (resp_cnt >= resp_lat) begin
                    int ix;
                    ix = {27'd0, req_space, req_addr[3:0]};
                    if (req_write) mem_model[ix] = f_merge(mem_model[ix], req_wdata, req_be);
                    req_rdata = mem_model[ix];
                    req_ready = 1;
                    resp_cnt  = 0;
                    chk(wait_out_n == 0, "R4", "wait low while pending", wait_out_n, 0);
                end else begin
                    resp_cnt++;
                end
            end
        end
    end

    task automatic bus_cycle(input bit wr, input bit sp, input logic [20:0] a,
                             input logic [1:0] lanes, input logic [15:0] d,
                             input int lat, input int hold);
        int guard;
        logic [15:0] m;
        m = {{8{lanes[1]}}, {8{lanes[0]}}};
        resp_lat = lat;
        resp_cnt = 0;
        @(negedge clk);
        bus_addr = a; bus_space = sp; bus_din = d; bus_cs_n = 0;
        if (wr) {bus_wr_hi_n, bus_wr_lo_n} = ~lanes;
        else    {bus_rd_hi_n, bus_rd_lo_n} = ~lanes;
        #1;
        chk(wait_oe == 1, "R2", "wait enable immediate", wait_oe, 1);
        chk(wait_out_n == 0, "R2", "wait level low", wait_out_n, 0);
        if (!wr) chk(bus_doe == lanes, "R7", "read lane enables", bus_doe, lanes);
        else     chk(bus_doe == 2'b00, "R7", "no drive on write", bus_doe, 0);
        @(negedge clk);
        chk(req_valid == 0, "R3", "no request after sampling edge", req_valid, 0);
        @(negedge clk);
        chk(req_valid == 1, "R3", "request on second edge", req_valid, 1);
        chk(req_write == wr, "R5", "write flag", req_write, wr);
        chk(req_space == sp, "R5", "space", req_space, sp);
        chk(req_addr == a, "R5", "address", req_addr, a);
        chk(req_be == lanes, "R10", "byte enables", req_be, lanes);
        if (wr) chk(req_wdata == d, "R6", "write data", req_wdata, d);
        guard = 0;
        while (!wait_out_n && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(wait_out_n == 1, "R4", "wait released", wait_out_n, 1);
        if (wr) begin
            exp_mem[f_idx(sp, a)] = f_merge(exp_mem[f_idx(sp, a)], d, lanes);
        end else begin
            chk((bus_dout & m) == (exp_mem[f_idx(sp, a)] & m), "R7", "read data",
                bus_dout & m, exp_mem[f_idx(sp, a)] & m);
        end
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(req_valid == 0, "R9", "no reissue while strobes low", req_valid, 0);
            chk(wait_out_n == 1, "R9", "wait stays released", wait_out_n, 1);
        end
        bus_cs_n = 1; bus_rd_lo_n = 1; bus_rd_hi_n = 1; bus_wr_lo_n = 1; bus_wr_hi_n = 1;
        #1;
        chk(wait_oe == 0, "R8", "wait floats on release", wait_oe, 0);
        chk(bus_doe == 2'b00, "R8", "data floats on release", bus_doe, 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            mem_model[i] = '0;
            exp_mem[i]   = '0;
        end
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(wait_oe == 0, "R1", "reset wait enable", wait_oe, 0);
        chk(bus_doe == 2'b00, "R1", "reset data enable", bus_doe, 0);
        chk(req_valid == 0, "R1", "reset request", req_valid, 0);

        // directed: full write, partial write, read back (R10)
        bus_cycle(1, 1, 21'h1A0005, 2'b11, 16'hA5C3, 0, 0);
        bus_cycle(1, 1, 21'h1A0005, 2'b01, 16'h1177, 2, 0);
        bus_cycle(0, 1, 21'h1A0005, 2'b11, 16'h0000, 1, 0);
        chk(bus_dout == 16'hA577, "R10", "untouched high lane kept", bus_dout, 16'hA577);
        // directed: strobes held low after completion (R9)
        bus_cycle(0, 0, 21'h000003, 2'b10, 16'h0000, 3, 5);
        bus_cycle(1, 0, 21'h0FFFFF, 2'b10, 16'hBEEF, 0, 4);
        bus_cycle(0, 0, 21'h0FFFFF, 2'b01, 16'h0000, 0, 0);

        for (int n = 0; n < 60; n++) begin
            bit wr, sp;
            logic [20:0] a;
            logic [1:0] ln;
            wr = $urandom_range(0, 1);
            sp = $urandom_range(0, 1);
            a  = 21'($urandom);
            ln = 2'($urandom_range(1, 3));
            bus_cycle(wr, sp, a, ln, 16'($urandom), $urandom_range(0, 4),
                      $urandom_range(0, 2));
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule